// File: doc/BRIEF.md
# Bearer Channel FIFO Pair with Threshold Events

This block holds the receive and transmit byte queues of one 64 kbps bearer channel and turns their fill levels into host events. Received bytes arrive from the line side one per cycle and are queued for the host. Host bytes are queued for the transmitter. Both queues are 128 bytes deep. The host services the channel in blocks whose size is the programmable threshold, either 64 or 96 bytes. The block tells the host when a full block of a frame has arrived and when a block's worth of transmit space has opened. It also reports the end of a frame, together with the frame length and a CRC error flag supplied by the framer. Receive overflow and transmit underrun are reported as well.

Events collect in an eight-bit pending register that is cleared by reading it. One interrupt line is active while any bit is pending. In an optional 56 kbps mode, the most significant bit of every octet is forced to 1 in both directions.

The line-side receive input has no ready signal. A byte offered with `rx_in_valid` is always taken. When the receive queue is full, the oldest byte is dropped to make room. The host-side receive output is first-word-fall-through: `rx_out_data` is valid while `rx_out_valid` is high, and a byte leaves the queue on a cycle with both valid and ready high. The host-side transmit input is accepted only while `tx_in_ready` is high, which means the queue is not full. Bytes offered while it is low are not taken. The transmit output follows the same valid/ready rule as the receive output. `tx_out_ready` means the transmitter wants a byte in that cycle.

Top module: `bearer_fifo_evt`

## Requirements
- R1: The threshold is 64 bytes after reset. A cycle with `thr_wr` high and `thr_code` 2'b00 selects 64, and `thr_code` 2'b10 selects 96. Codes 2'b01 and 2'b11 leave the current threshold unchanged.
- R2: Each accepted receive byte that is not the last of a frame raises the receive-ready event (pending bit 0) when it brings the byte count of the current block to the threshold. The block count then restarts at zero.
- R3: An accepted receive byte with `rx_in_last` high raises the end-of-frame event (pending bit 1). On the next cycle, `frame_len` holds the number of bytes in the frame including the last one, and `frame_crc_err` holds the `rx_in_crc_err` value given with that byte. Both the frame count and the block count restart.
- R4: When the last byte of a frame completes a block of exactly the threshold size, only bit 1 is raised, not bit 0.
- R5: A receive byte arriving while the receive queue holds 128 bytes and no byte leaves in that cycle raises the overflow event (pending bit 2). The oldest byte is discarded, the new byte is stored at the tail, and the occupancy stays at 128.
- R6: The transmit-ready event (pending bit 3) is raised in a cycle where the number of free transmit entries rises from below the threshold to at least the threshold.
- R7: The underrun event (pending bit 4) is raised when `tx_out_ready` is high and the transmit queue is empty while a frame is open. A frame is open after a byte stored with `tx_in_last` low has left the queue. It closes when a byte stored with `tx_in_last` high leaves, and after reset.
- R8: The pending register `ir_q` is 8'h00 after reset, and bits 7:5 are always 0. A cycle with `ir_rd` high clears it, except that an event raised in that same cycle stays pending. `irq` is high exactly when `ir_q` is nonzero.
- R9: While `mode56` is high, a received byte is stored with bit 7 set, and `tx_out_data` shows bit 7 set.
- R10: Each queue returns bytes in arrival order. `rx_out_valid` and `tx_out_valid` are high exactly when the corresponding queue is not empty. `tx_in_ready` is high exactly when the transmit queue holds fewer than 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_wr | input | 1 | Load threshold code this cycle |
| thr_code | input | 2 | Threshold code (00: 64, 10: 96, others ignored) |
| mode56 | input | 1 | Force octet bit 7 to 1 |
| rx_in_valid | input | 1 | Received byte present (always taken) |
| rx_in_data | input | 8 | Received byte |
| rx_in_last | input | 1 | Byte is the last of its frame |
| rx_in_crc_err | input | 1 | CRC result of the frame, valid with the last byte |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | Host takes the head receive byte |
| rx_out_data | output | 8 | Head receive byte |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue can accept a byte |
| tx_in_data | input | 8 | Transmit byte |
| tx_in_last | input | 1 | Transmit byte closes its frame |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_ready | input | 1 | Transmitter wants a byte |
| tx_out_data | output | 8 | Head transmit byte |
| ir_rd | input | 1 | Read-and-clear of the pending register |
| ir_q | output | 8 | Pending events (bit 0 rx ready, 1 frame end, 2 overflow, 3 tx ready, 4 underrun) |
| irq | output | 1 | Any event pending |
| frame_len | output | 16 | Length of the last completed receive frame |
| frame_crc_err | output | 1 | CRC error flag of the last completed frame |

## Verification
A wrong block counter would show up in `ir_q` within one cycle of the byte that should have completed a block: bit 0 would be set where bit 1 alone belongs, or missing where it is due. A slipped queue pointer shows up as a wrong `rx_out_data` or `tx_out_data` value in the first cycle the host looks at the affected byte. That can be many cycles after the write, so the model compares the head bytes on every clock. Wrong occupancy shows up at `tx_in_ready` or `rx_out_valid` in the cycle the count crosses full or empty. It also shows up as a missing or extra bit 2 or bit 3 in `ir_q` one cycle later.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  localparam int FIFO_DEPTH = 128;
  localparam int THR_LO     = 64;
  localparam int THR_HI     = 96;
  localparam int THR_W      = $clog2(THR_HI + 1);
  localparam int LEN_W      = 16;
  localparam int EVT_W      = 8;

  localparam int EV_RX_RDY  = 0;
  localparam int EV_RX_END  = 1;
  localparam int EV_RX_OVF  = 2;
  localparam int EV_TX_RDY  = 3;
  localparam int EV_TX_UND  = 4;

  typedef enum logic [1:0] {
    THR_SEL_LO   = 2'b00,
    THR_SEL_RSV  = 2'b01,
    THR_SEL_HI   = 2'b10,
    THR_SEL_BAD  = 2'b11
  } thr_sel_e;
endpackage

// File: rtl/bfe_fifo.sv
module bfe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          ovw,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          is_empty, is_full, do_pop, do_drop, do_push, rd_adv;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_empty = (cnt == '0);
  assign is_full  = (cnt == CW'(DEPTH));
  assign do_pop   = pop && !is_empty;
  assign do_drop  = push && is_full && !do_pop && ovw;
  assign do_push  = push && (!is_full || do_pop || ovw);
  assign rd_adv   = do_pop || do_drop;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (rd_adv)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !rd_adv)      cnt <= cnt + 1'b1;
      else if (!do_push && rd_adv) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/bfe_rx_track.sv
module bfe_rx_track #(
  parameter int THRW = 7,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_en,
  input  logic            last,
  input  logic            crc_err,
  input  logic [THRW-1:0] thr,
  output logic            evt_rdy,
  output logic            evt_end,
  output logic [LENW-1:0] frame_len,
  output logic            crc_flag
);
  logic [THRW:0]   blk_q;
  logic [THRW:0]   blk_inc;
  logic [LENW-1:0] frm_q;

  assign blk_inc = blk_q + 1'b1;
  assign evt_end = byte_en && last;
  assign evt_rdy = byte_en && !last && (blk_inc >= {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q     <= '0;
      frm_q     <= '0;
      frame_len <= '0;
      crc_flag  <= 1'b0;
    end else if (byte_en) begin
      if (last) begin
        frame_len <= frm_q + 1'b1;
        crc_flag  <= crc_err;
        frm_q     <= '0;
        blk_q     <= '0;
      end else begin
        frm_q <= frm_q + 1'b1;
        blk_q <= evt_rdy ? '0 : blk_inc;
      end
    end
  end
endmodule

// File: rtl/bfe_evt_reg.sv
module bfe_evt_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (clr ? '0 : pend) | evt;
  end
  assign irq = |pend;
endmodule

// File: rtl/bearer_fifo_evt.sv
module bearer_fifo_evt
  import bfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [1:0]        thr_code,
  input  logic              mode56,
  input  logic              rx_in_valid,
  input  logic [7:0]        rx_in_data,
  input  logic              rx_in_last,
  input  logic              rx_in_crc_err,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [7:0]        rx_out_data,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [7:0]        tx_in_data,
  input  logic              tx_in_last,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [7:0]        tx_out_data,
  input  logic              ir_rd,
  output logic [EVT_W-1:0]  ir_q,
  output logic              irq,
  output logic [LEN_W-1:0]  frame_len,
  output logic              frame_crc_err
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW:0] DEPTH_V = (CW + 1)'(FIFO_DEPTH);

  logic [THR_W-1:0] thr_q;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic             rx_full, rx_pop, tx_pop, tx_push, tx_empty;
  logic [7:0]       rx_store;
  logic [8:0]       tx_dout;
  logic             tx_open_q;
  logic             ev_rx_rdy, ev_rx_end, ev_tx_rdy, ev_tx_und, ev_rx_ovf;
  logic [CW:0]      free_now, free_nxt, thr_ext;
  logic [EVT_W-1:0] evt;

  // threshold select: only the two valid codes load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_W'(THR_LO);
    else if (thr_wr) begin
      case (thr_sel_e'(thr_code))
        THR_SEL_LO: thr_q <= THR_W'(THR_LO);
        THR_SEL_HI: thr_q <= THR_W'(THR_HI);
        default:    thr_q <= thr_q;
      endcase
    end
  end

  // receive path
  assign rx_full      = (rx_cnt == CW'(FIFO_DEPTH));
  assign rx_out_valid = (rx_cnt != '0);
  assign rx_pop       = rx_out_valid && rx_out_ready;
  assign rx_store     = {rx_in_data[7] | mode56, rx_in_data[6:0]};
  assign ev_rx_ovf    = rx_in_valid && rx_full && !rx_pop;

  bfe_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (rx_in_valid),
    .pop  (rx_pop),
    .ovw  (1'b1),
    .din  (rx_store),
    .dout (rx_out_data),
    .cnt  (rx_cnt)
  );

  bfe_rx_track #(.THRW(THR_W), .LENW(LEN_W)) rx_trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_en  (rx_in_valid),
    .last     (rx_in_last),
    .crc_err  (rx_in_crc_err),
    .thr      (thr_q),
    .evt_rdy  (ev_rx_rdy),
    .evt_end  (ev_rx_end),
    .frame_len(frame_len),
    .crc_flag (frame_crc_err)
  );

  // transmit path
  assign tx_empty     = (tx_cnt == '0);
  assign tx_in_ready  = (tx_cnt != CW'(FIFO_DEPTH));
  assign tx_out_valid = !tx_empty;
  assign tx_push      = tx_in_valid && tx_in_ready;
  assign tx_pop       = tx_out_valid && tx_out_ready;
  assign tx_out_data  = {tx_dout[7] | mode56, tx_dout[6:0]};

  bfe_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk  (clk),
    .rst_n(rst_n),
    .push (tx_push),
    .pop  (tx_pop),
    .ovw  (1'b0),
    .din  ({tx_in_last, tx_in_data}),
    .dout (tx_dout),
    .cnt  (tx_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_open_q <= 1'b0;
    else if (tx_pop) tx_open_q <= !tx_dout[8];
  end

  assign thr_ext   = (CW + 1)'(thr_q);
  assign free_now  = DEPTH_V - {1'b0, tx_cnt};
  assign free_nxt  = free_now + {{CW{1'b0}}, tx_pop} - {{CW{1'b0}}, tx_push};
  assign ev_tx_rdy = (free_now < thr_ext) && (free_nxt >= thr_ext);
  assign ev_tx_und = tx_out_ready && tx_empty && tx_open_q;

  // event collection
  always_comb begin
    evt            = '0;
    evt[EV_RX_RDY] = ev_rx_rdy;
    evt[EV_RX_END] = ev_rx_end;
    evt[EV_RX_OVF] = ev_rx_ovf;
    evt[EV_TX_RDY] = ev_tx_rdy;
    evt[EV_TX_UND] = ev_tx_und;
  end

  bfe_evt_reg #(.N(EVT_W)) evt_reg_i (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt),
    .clr  (ir_rd),
    .pend (ir_q),
    .irq  (irq)
  );
endmodule

// File: rtl/bearer_fifo_evt_chk.sv
module bearer_fifo_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_in_valid,
  input logic       rx_in_last,
  input logic       rx_out_valid,
  input logic       rx_out_ready,
  input logic [7:0] rx_out_data,
  input logic       tx_out_ready,
  input logic       mode56,
  input logic       ir_rd,
  input logic [7:0] ir_q,
  input logic       rx_full
);
  // R3
  frame_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_last) |=> ir_q[1]);

  // R4
  exact_block_no_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_last && ir_rd) |=> !ir_q[0]);

  // R5
  rx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_in_valid && !(rx_out_valid && rx_out_ready)) |=> ir_q[2]);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_rd && !rx_in_valid && !tx_out_ready) |=> (ir_q == 8'h00));

  // R9
  msb_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode56 && rx_in_valid && !rx_out_valid) |=> rx_out_data[7]);

  // R10
  rx_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready && !rx_in_valid) |=> (rx_out_valid && $stable(rx_out_data)));
endmodule

bind bearer_fifo_evt bearer_fifo_evt_chk chk_i (.*);

// File: tb/bearer_fifo_evt_tb_top.sv
module bearer_fifo_evt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       thr_wr = 0;
  logic [1:0] thr_code = 0;
  logic       mode56 = 0;
  logic       rx_in_valid = 0, rx_in_last = 0, rx_in_crc_err = 0;
  logic [7:0] rx_in_data = 0;
  logic       rx_out_valid, rx_out_ready = 0;
  logic [7:0] rx_out_data;
  logic       tx_in_valid = 0, tx_in_last = 0, tx_in_ready;
  logic [7:0] tx_in_data = 0;
  logic       tx_out_valid, tx_out_ready = 0;
  logic [7:0] tx_out_data;
  logic       ir_rd = 0;
  logic [7:0] ir_q;
  logic       irq;
  logic [15:0] frame_len;
  logic       frame_crc_err;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  bearer_fifo_evt dut_i (.*);

  // behavioural reference model
  logic [7:0] m_rxq[$];
  logic [8:0] m_txq[$];
  int         m_thr, m_blk, m_flen;
  logic [15:0] m_len;
  logic       m_crc, m_open;
  logic [7:0] m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxq.delete(); m_txq.delete();
      m_thr = 64; m_blk = 0; m_flen = 0; m_len = 0; m_crc = 0; m_open = 0; m_pend = 0;
    end else begin
      logic [7:0] ev;
      int fb, fa;
      bit rp, tp, tw;
      ev = 0;
      rp = (m_rxq.size() > 0) && rx_out_ready;
      if (rp) void'(m_rxq.pop_front());
      if (rx_in_valid) begin
        if (m_rxq.size() == 128) begin void'(m_rxq.pop_front()); ev[2] = 1; end
        m_rxq.push_back({rx_in_data[7] | mode56, rx_in_data[6:0]});
        if (rx_in_last) begin
          ev[1] = 1; m_len = 16'(m_flen + 1); m_crc = rx_in_crc_err; m_flen = 0; m_blk = 0;
        end else begin
          m_flen++;
          m_blk++;
          if (m_blk >= m_thr) begin ev[0] = 1; m_blk = 0; end
        end
      end
      fb = 128 - m_txq.size();
      if (tx_out_ready && m_txq.size() == 0 && m_open) ev[4] = 1;
      tp = (m_txq.size() > 0) && tx_out_ready;
      tw = tx_in_valid && (m_txq.size() < 128);
      if (tp) begin m_open = !m_txq[0][8]; void'(m_txq.pop_front()); end
      if (tw) m_txq.push_back({tx_in_last, tx_in_data});
      fa = 128 - m_txq.size();
      if (fb < m_thr && fa >= m_thr) ev[3] = 1;
      if (thr_wr && thr_code == 2'b00) m_thr = 64;
      if (thr_wr && thr_code == 2'b10) m_thr = 96;
      m_pend = (ir_rd ? 8'h00 : m_pend) | ev;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(ir_q === m_pend, "R8 pending register (R2 R4 R5 R6 R7 bits)", ir_q, m_pend);
      chk(irq === (m_pend != 0), "R8 irq line", irq, m_pend != 0);
      chk(rx_out_valid === (m_rxq.size() > 0), "R10 rx_out_valid", rx_out_valid, m_rxq.size() > 0);
      if (m_rxq.size() > 0)
        chk(rx_out_data === m_rxq[0], "R10 R5 R9 rx head byte", rx_out_data, m_rxq[0]);
      chk(tx_in_ready === (m_txq.size() < 128), "R10 tx_in_ready", tx_in_ready, m_txq.size() < 128);
      chk(tx_out_valid === (m_txq.size() > 0), "R10 tx_out_valid", tx_out_valid, m_txq.size() > 0);
      if (m_txq.size() > 0)
        chk(tx_out_data === {m_txq[0][7] | mode56, m_txq[0][6:0]}, "R9 R10 tx head byte",
            tx_out_data, {m_txq[0][7] | mode56, m_txq[0][6:0]});
      chk(frame_len === m_len, "R3 frame_len", frame_len, m_len);
      chk(frame_crc_err === m_crc, "R3 frame_crc_err", frame_crc_err, m_crc);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    thr_wr = 0; rx_in_valid = 0; rx_in_last = 0; tx_in_valid = 0; tx_in_last = 0; ir_rd = 0;
  endtask

  task automatic clear_ir();
    ir_rd = 1; tick(); ir_rd = 0;
  endtask

  task automatic set_thr(input logic [1:0] c);
    thr_wr = 1; thr_code = c; tick(); thr_wr = 0;
  endtask

  task automatic rx_frame(input int n, input bit crc, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rx_in_valid = 1; rx_in_data = base + 8'(i); rx_in_last = (i == n - 1); rx_in_crc_err = crc;
      tick();
    end
    rx_in_valid = 0; rx_in_last = 0;
  endtask

  task automatic drain_rx();
    rx_out_ready = 1; repeat (140) tick(); rx_out_ready = 0;
  endtask

  task automatic run_all();
    repeat (3) tick();
    rst_n = 1; tick();
    // reset state
    chk(ir_q === 8'h00, "R8 reset ir_q", ir_q, 0);
    chk(irq === 1'b0, "R8 reset irq", irq, 0);
    chk(rx_out_valid === 1'b0, "R10 reset rx empty", rx_out_valid, 0);
    chk(tx_in_ready === 1'b1, "R10 reset tx ready", tx_in_ready, 1);
    cmp_on = 1;

    // exact 64-byte frame: only end-of-frame
    rx_frame(64, 0, 8'h10); tick();
    chk(ir_q === 8'h02, "R4 exact block gives end only", ir_q, 8'h02);
    chk(frame_len === 16'd64, "R3 length 64", frame_len, 64);
    clear_ir(); drain_rx(); clear_ir();

    // 74-byte frame with CRC error: ready then end
    rx_frame(74, 1, 8'h40); tick();
    chk(ir_q === 8'h03, "R2 block ready plus end", ir_q, 8'h03);
    chk(frame_crc_err === 1'b1, "R3 crc flag", frame_crc_err, 1);
    clear_ir();
    // overflow: 60 more bytes on top of 74
    for (int i = 0; i < 60; i++) begin rx_in_valid = 1; rx_in_data = 8'(i); tick(); end
    idle(); tick();
    chk(ir_q === 8'h04, "R5 overflow flagged", ir_q, 8'h04);
    chk(rx_out_data === 8'h46, "R5 oldest bytes dropped", rx_out_data, 8'h46);
    clear_ir(); drain_rx(); clear_ir();

    // threshold codes
    set_thr(2'b01);
    rx_frame(70, 0, 8'h00); tick();
    chk(ir_q === 8'h03, "R1 reserved code keeps 64", ir_q, 8'h03);
    clear_ir(); drain_rx();
    set_thr(2'b10); clear_ir();
    rx_frame(100, 0, 8'h20); tick();
    chk(ir_q === 8'h03, "R1 code 10 selects 96", ir_q, 8'h03);
    clear_ir(); drain_rx();
    set_thr(2'b11); clear_ir();
    rx_frame(96, 0, 8'h30); tick();
    chk(ir_q === 8'h02, "R1 R4 forbidden code keeps 96, exact block", ir_q, 8'h02);
    clear_ir(); drain_rx(); clear_ir();

    // 56 kbps mode
    mode56 = 1;
    rx_frame(2, 0, 8'h00); tick();
    chk(rx_out_data === 8'h80, "R9 msb forced on receive", rx_out_data, 8'h80);
    mode56 = 0; drain_rx(); clear_ir();

    // transmit fill, then drain with threshold 64
    for (int i = 0; i < 130; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(i); tx_in_last = (i == 127); tick();
    end
    idle();
    chk(tx_in_ready === 1'b0, "R10 tx full not ready", tx_in_ready, 0);
    set_thr(2'b00); clear_ir();
    tx_out_ready = 1; repeat (130) tick(); tx_out_ready = 0; tick();
    chk(ir_q === 8'h08, "R6 tx space event, no underrun after closed frame", ir_q, 8'h08);
    clear_ir();
    for (int i = 0; i < 3; i++) begin tx_in_valid = 1; tx_in_data = 8'hA0 + 8'(i); tick(); end
    idle();
    tx_out_ready = 1; repeat (5) tick(); tx_out_ready = 0; tick();
    chk(ir_q === 8'h10, "R7 underrun in open frame", ir_q, 8'h10);
    clear_ir();

    // event in the same cycle as a clearing read
    rx_in_valid = 1; rx_in_last = 1; rx_in_data = 8'h55; ir_rd = 1; tick(); idle(); tick();
    chk(ir_q === 8'h02, "R8 event kept on clearing read", ir_q, 8'h02);
    chk(irq === 1'b1, "R8 irq follows pending", irq, 1);
    clear_ir(); drain_rx(); clear_ir();

    // random traffic
    for (int c = 0; c < 6000; c++) begin
      rx_in_valid = ($urandom % 3) == 0;
      rx_in_data = 8'($urandom); rx_in_last = ($urandom % 50) == 0; rx_in_crc_err = $urandom % 2;
      rx_out_ready = (c % 2000) < 1000 ? ($urandom % 4) != 0 : ($urandom % 8) == 0;
      tx_in_valid = ($urandom % 2) == 0; tx_in_data = 8'($urandom); tx_in_last = ($urandom % 30) == 0;
      tx_out_ready = (c % 1500) < 700 ? ($urandom % 5) == 0 : ($urandom % 3) != 0;
      ir_rd = ($urandom % 12) == 0;
      thr_wr = ($urandom % 300) == 0; thr_code = 2'($urandom);
      if (($urandom % 700) == 0) mode56 = ~mode56;
      tick();
    end
    idle(); rx_out_ready = 0; tx_out_ready = 0; tick(); tick();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule